// File: doc/BRIEF.md
# Macro Expansion Word Sequencer

This block sits behind the parsing stage of an assembler and turns two kinds of pseudo-instruction requests into the basic 32-bit machine words that carry them out. The two kinds are load-immediate and register multiply. Each request carries a kind code, a destination register, two source registers and a 32-bit immediate. The block accepts a request in a single cycle. It then works out whether the expansion takes one word or two and presents the words one at a time on a valid/ready output.

A load-immediate whose value fits in the low half becomes a single OR-immediate against the zero register. A wider value first loads its upper half into the assembler-temporary register (register 1). A second word then ORs the lower half from that register into the destination. A multiply becomes a multiply into the hi/lo pair, followed by a move-from-lo into the destination.

The input is held off until the last word of the current expansion has been taken. A request with an unknown kind is consumed without producing any word, and it raises a one-cycle error pulse instead.

Top module: `macro_expander`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err_pulse is 0.
- R2: A load-immediate request (kind 2'b01) whose imm[31:16] is zero yields exactly one word: opcode 13 in [31:26], 0 in [25:21], rd in [20:16], imm[15:0] in [15:0].
- R3: A load-immediate request whose imm[31:16] is nonzero yields two words in order. The first is opcode 15 in [31:26], 0 in [25:21], 1 in [20:16] and imm[31:16] in [15:0]. The second is opcode 13, 1 in [25:21], rd in [20:16] and imm[15:0] in [15:0].
- R4: A multiply request (kind 2'b10) yields two words in order. The first has opcode 0, rs in [25:21], rt in [20:16], zeros in [15:6] and funct 24 in [5:0]. The second has opcode 0, zeros in [25:16], rd in [15:11], zero in [10:6] and funct 18 in [5:0].
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_word stays unchanged on the next cycle.
- R6: A request of kind 2'b00 or 2'b11 is accepted and produces no word. err_pulse is 1 for exactly the one cycle after acceptance, and out_valid is 0 during that cycle.
- R7: in_ready is 0 from the acceptance of a request until its last word has been taken. A request presented during that time is not taken and does not disturb the words being emitted.
- R8: After the last word is taken, in_ready returns to 1 in the next cycle and out_valid drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_kind | input | 2 | 01 load-immediate, 10 multiply, other values unknown |
| in_rd | input | 5 | Destination register |
| in_rs | input | 5 | First source register (multiply) |
| in_rt | input | 5 | Second source register (multiply) |
| in_imm | input | 32 | Immediate value (load-immediate) |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Encoded machine word |
| err_pulse | output | 1 | One-cycle flag for a dropped unknown request |

## Verification
Two things can happen in the same cycle: a new request arrives at the input while a two-word expansion is stalled at the output.

The bench provokes this by holding out_ready low in the middle of a sequence while in_valid is driven with a different request. For each stalled cycle it judges two things: in_ready must stay low, and out_word must not move. When the final word is released, the bench checks that only the original words came out and that the block is ready again.

// File: rtl/macro_pkg.sv
package macro_pkg;
    localparam int OP_W   = 6;
    localparam int REG_W  = 5;
    localparam int SH_W   = 5;
    localparam int FN_W   = 6;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int KIND_W = 2;

    localparam logic [OP_W-1:0]  OPC_SPECIAL = OP_W'(0);
    localparam logic [OP_W-1:0]  OPC_ORI     = OP_W'(13);
    localparam logic [OP_W-1:0]  OPC_LUI     = OP_W'(15);
    localparam logic [FN_W-1:0]  FN_MULT     = FN_W'(24);
    localparam logic [FN_W-1:0]  FN_MFLO     = FN_W'(18);
    localparam logic [REG_W-1:0] REG_ZERO    = REG_W'(0);
    localparam logic [REG_W-1:0] REG_AT      = REG_W'(1);

    typedef enum logic [KIND_W-1:0] {
        K_NONE = 2'b00,
        K_LI   = 2'b01,
        K_MUL  = 2'b10,
        K_RSV  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic              two;
        logic              err;
    } seq_s;
endpackage

// File: rtl/rtype_enc.sv
module rtype_enc
    import macro_pkg::*;
(
    input  logic [REG_W-1:0]  rs,
    input  logic [REG_W-1:0]  rt,
    input  logic [REG_W-1:0]  rd,
    input  logic [FN_W-1:0]   funct,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = {OPC_SPECIAL, rs, rt, rd, SH_W'(0), funct};
    end
endmodule

// File: rtl/itype_enc.sv
module itype_enc
    import macro_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [REG_W-1:0]  rs,
    input  logic [REG_W-1:0]  rt,
    input  logic [HALF_W-1:0] imm,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = {op, rs, rt, imm};
    end
endmodule

// File: rtl/macro_planner.sv
module macro_planner
    import macro_pkg::*;
(
    input  kind_e             kind,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs,
    input  logic [REG_W-1:0]  rt,
    input  logic [WORD_W-1:0] imm,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1,
    output logic              two,
    output logic              bad
);
    logic [HALF_W-1:0] hi_half;
    logic [HALF_W-1:0] lo_half;
    logic              narrow;
    logic [REG_W-1:0]  ori_base;
    logic [WORD_W-1:0] lui_w, ori_w, mult_w, mflo_w;

    assign hi_half  = imm[WORD_W-1:HALF_W];
    assign lo_half  = imm[HALF_W-1:0];
    assign narrow   = (hi_half == '0);
    assign ori_base = narrow ? REG_ZERO : REG_AT;

    itype_enc u_lui (
        .op(OPC_LUI), .rs(REG_ZERO), .rt(REG_AT), .imm(hi_half), .word(lui_w)
    );
    itype_enc u_ori (
        .op(OPC_ORI), .rs(ori_base), .rt(rd), .imm(lo_half), .word(ori_w)
    );
    rtype_enc u_mult (
        .rs(rs), .rt(rt), .rd(REG_ZERO), .funct(FN_MULT), .word(mult_w)
    );
    rtype_enc u_mflo (
        .rs(REG_ZERO), .rt(REG_ZERO), .rd(rd), .funct(FN_MFLO), .word(mflo_w)
    );

    always_comb begin
        w0  = '0;
        w1  = '0;
        two = 1'b0;
        bad = 1'b0;
        unique case (kind)
            K_LI: begin
                if (narrow) begin
                    w0 = ori_w;
                end else begin
                    w0  = lui_w;
                    w1  = ori_w;
                    two = 1'b1;
                end
            end
            K_MUL: begin
                w0  = mult_w;
                w1  = mflo_w;
                two = 1'b1;
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/macro_expander.sv
module macro_expander
    import macro_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [REG_W-1:0]  in_rs,
    input  logic [REG_W-1:0]  in_rt,
    input  logic [WORD_W-1:0] in_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              err_pulse
);
    seq_s seq_d, seq_q;

    logic [WORD_W-1:0] plan_w0, plan_w1;
    logic              plan_two, plan_bad;

    macro_planner u_plan (
        .kind (kind_e'(in_kind)),
        .rd   (in_rd),
        .rs   (in_rs),
        .rt   (in_rt),
        .imm  (in_imm),
        .w0   (plan_w0),
        .w1   (plan_w1),
        .two  (plan_two),
        .bad  (plan_bad)
    );

    assign in_ready  = (seq_q.st == ST_IDLE);
    assign out_valid = (seq_q.st != ST_IDLE);
    assign out_word  = (seq_q.st == ST_SECOND) ? seq_q.w1 : seq_q.w0;
    assign err_pulse = seq_q.err;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (plan_bad) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st  = ST_FIRST;
                        seq_d.w0  = plan_w0;
                        seq_d.w1  = plan_w1;
                        seq_d.two = plan_two;
                    end
                end
            end
            ST_FIRST: begin
                if (out_ready) begin
                    seq_d.st = seq_q.two ? ST_SECOND : ST_IDLE;
                end
            end
            ST_SECOND: begin
                if (out_ready) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, w0: '0, w1: '0, two: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R1 / R8: right after reset the block is idle and quiet
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (in_ready && !out_valid && !err_pulse));

    // R7: no request is taken while a word is pending
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5: a stalled word holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R6: the error flag lasts one cycle and emits nothing
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
    p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !out_valid);

    // R3: a taken upper-half load is followed by an OR from the temporary
    p_lui_then_ori_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_word[WORD_W-1 -: OP_W] == OPC_LUI)
        |=> (out_valid && out_word[WORD_W-1 -: OP_W] == OPC_ORI
             && out_word[25:21] == REG_AT));

    // R4: a taken multiply is followed by a move-from-lo
    p_mult_then_mflo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_word[WORD_W-1 -: OP_W] == OPC_SPECIAL
         && out_word[FN_W-1:0] == FN_MULT)
        |=> (out_valid && out_word[FN_W-1:0] == FN_MFLO));

    // R8: after the last word the block is idle again
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_word[FN_W-1:0] == FN_MFLO
         && out_word[WORD_W-1 -: OP_W] == OPC_SPECIAL)
        |=> (in_ready && !out_valid));
endmodule

// File: tb/tb_macro_expander.sv
`timescale 1ns/100ps
module tb_macro_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'b00;
    logic [4:0]  in_rd = '0, in_rs = '0, in_rt = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        err_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    macro_expander dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .err_pulse(err_pulse)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [1:0]  kind;
        logic [4:0]  rd;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [31:0] imm;
        logic [1:0]  n;
        logic [31:0] w0;
        logic [31:0] w1;
        logic        err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{"R2", 2'b01, 5'd9,  5'd0, 5'd0,  32'h0000_ABCD, 2'd1, 32'h3409_ABCD, 32'h0, 1'b0},
        '{"R2", 2'b01, 5'd31, 5'd0, 5'd0,  32'h0000_FFFF, 2'd1, 32'h341F_FFFF, 32'h0, 1'b0},
        '{"R3", 2'b01, 5'd8,  5'd0, 5'd0,  32'h1234_ABCD, 2'd2, 32'h3C01_1234, 32'h3428_ABCD, 1'b0},
        '{"R3", 2'b01, 5'd2,  5'd0, 5'd0,  32'h0001_0000, 2'd2, 32'h3C01_0001, 32'h3422_0000, 1'b0},
        '{"R4", 2'b10, 5'd8,  5'd9, 5'd10, 32'h0,         2'd2, 32'h012A_0018, 32'h0000_4012, 1'b0},
        '{"R4", 2'b10, 5'd16, 5'd4, 5'd5,  32'hFFFF_FFFF, 2'd2, 32'h0085_0018, 32'h0000_8012, 1'b0},
        '{"R6", 2'b00, 5'd3,  5'd1, 5'd2,  32'h0000_0001, 2'd0, 32'h0,         32'h0, 1'b1},
        '{"R6", 2'b11, 5'd7,  5'd1, 5'd2,  32'h8000_0000, 2'd0, 32'h0,         32'h0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int stall);
        logic [31:0] expw;
        @(negedge clk);
        in_kind = v.kind; in_rd = v.rd; in_rs = v.rs; in_rt = v.rt; in_imm = v.imm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk($sformatf("%s err flag", v.tag), {31'b0, err_pulse}, {31'b0, v.err});
        if (v.n == 2'd0) begin
            chk("R6 no word during err", {31'b0, out_valid}, 32'd0);
            @(negedge clk);
            chk("R6 err one cycle", {31'b0, err_pulse}, 32'd0);
        end
        for (int i = 0; i < int'(v.n); i++) begin
            expw = (i == 0) ? v.w0 : v.w1;
            chk($sformatf("%s word%0d valid", v.tag, i), {31'b0, out_valid}, 32'd1);
            chk($sformatf("%s word%0d", v.tag, i), out_word, expw);
            for (int s = 0; s < stall; s++) begin
                in_kind = 2'b01; in_rd = 5'd20; in_imm = 32'h0000_0055;
                in_valid = 1'b1;
                @(negedge clk);
                chk("R7 input held off", {31'b0, in_ready}, 32'd0);
                chk("R5 word held", out_word, expw);
            end
            in_valid = 1'b0;
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk($sformatf("%s R8 idle after", v.tag), {30'b0, in_ready, out_valid}, 32'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {29'b0, in_ready, out_valid, err_pulse}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {29'b0, in_ready, out_valid, err_pulse}, 32'b100);

        for (int k = 0; k < NV; k++) run_vec(TBL[k], 0);

        // R5 / R7: stall mid-expansion with a competing request on the input
        run_vec(TBL[2], 3);
        run_vec(TBL[4], 2);
        // back-to-back: the competing request must not have slipped in
        run_vec(TBL[0], 0);
        chk("R7 no stray word", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule